// File: doc/BRIEF.md
# Packet Command Decoder for an Optical-Drive Host Interface

This block sits behind the data port of an ATA-style optical drive interface. Once the data port has collected a 12-byte command packet, the block takes the packet in a single cycle. It decodes the opcode in byte 0 and pulls out the parameters for that opcode. It clips each requested length to the size of the matching response. It then updates the status, error and stored sense state.

Commands that return data start a device-to-host byte stream. The host drains that stream through a simple read strobe. The identify response comes from a fixed 32-byte table that the block computes itself. The sense response is built from the stored error code. The disc-information response is taken from a stub input.

Media reads are handed to an external media port as a one-cycle request that carries the LBA, the block count and the read mode. Every packet raises an interrupt pulse as soon as it is accepted. The host-programmed byte-count limit is captured as the block size of the transfer.

Top module: `ata_pkt_decoder`

## Requirements
- R1: After reset: `ata_status` is 0x00, `ata_error` is 0x01, `xfer_active` is 0, `irq_pulse` is 0, `media_req` is 0 and `rd_data` reads 0xFF.
- R2: `irq_pulse` is high for one cycle right after the edge that accepts a packet (`pkt_valid` high). It is also high for one cycle after the edge that consumes the last byte of a response.
- R3: Opcode 0x00 (test-ready) sets status 0x50 and error 0x00 when `media_ready` is 1. When `media_ready` is 0 it raises the no-disc error.
- R4: A failing packet stores its 16-bit code, loads `ata_error` with (code & 0x0F) << 4 and sets status 0x51. The codes are: no-disc 0x3A02, invalid-field 0x2405, invalid-command 0x2005. Any opcode other than 0x00, 0x11, 0x13, 0x14 or 0x30 gives invalid-command. A successful packet clears the stored code and the error register.
- R5: Opcode 0x11 (identify) takes its start offset from byte 2 and its length from byte 4. An offset of 32 or more gives invalid-field. Otherwise the length is clipped to 32 − offset, and the stream starts at table entry `offset`, where entry k = 0xA0 XOR (7·k mod 256).
- R6: Opcode 0x13 (sense) streams min(byte 4, 10) bytes of a 10-byte record built from the code stored before the command: byte 0 = 0xF0, byte 2 = code[7:0], byte 8 = code[15:8], all others 0.
- R7: Opcode 0x14 (disc info) streams min(byte 4, 6) bytes, where byte k is `dinfo_bytes[8k+7:8k]`. It gives no-disc when `media_ready` is 0.
- R8: Opcode 0x30 (media read) takes the LBA from bytes 2..4 and the block count from bytes 8..10, most significant byte first. Mode byte 1 maps 0x20 and 0x28 to mode 0, 0x24 to mode 1 and 0x30 to mode 2. Any other mode byte gives invalid-field. If the mode is valid and `media_ready` is 0, the result is no-disc. Otherwise `media_req` pulses for one cycle with those fields and the status is 0x50. Packet byte k is `pkt_bytes[8k+7:8k]`.
- R9: A response with a length above zero holds status 0x58 with `xfer_active` high. Each `rd_en` cycle presents one byte on `rd_data`. After the last byte the status is 0x50. A clipped length of zero starts no transfer (status 0x50). A new packet aborts an open transfer. `rd_en` while idle has no effect and `rd_data` reads 0xFF.
- R10: `xfer_blksize` takes the value of `byte_limit` at the edge that accepts a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | One-cycle strobe: a complete packet is on `pkt_bytes` |
| pkt_bytes | input | 96 | Packet, byte k in bits 8k+7:8k |
| byte_limit | input | 16 | Host-programmed byte-count limit |
| media_ready | input | 1 | Media present and ready |
| dinfo_bytes | input | 48 | Disc-information stub, byte k in bits 8k+7:8k |
| rd_en | input | 1 | Host consumes the byte on `rd_data` |
| rd_data | output | 8 | Current response byte, 0xFF when idle |
| xfer_active | output | 1 | Response stream open |
| irq_pulse | output | 1 | Interrupt request pulse |
| ata_status | output | 8 | Status register |
| ata_error | output | 8 | Error register |
| xfer_blksize | output | 16 | Block size captured for the transfer |
| media_req | output | 1 | One-cycle media read request |
| media_lba | output | 24 | Requested LBA |
| media_count | output | 24 | Requested block count |
| media_mode | output | 2 | Read mode: 0, 1 or 2 |

## Verification
The bench targets the length clips at their edges: an identify offset of 30 must yield 2 bytes, an offset of 32 must fail, and sense and disc-info requests above the response size must be clipped. A design with an off-by-one clip would stream one byte too many or too few, and the scoreboard would flag a missing or surplus byte. Sense is read right after a failure and again after a success, so a design that snapshots the code too late, or never clears it, would return the wrong bytes 2 and 8. The bench also strobes `rd_en` while idle, aborts a transfer midway with a new packet, and sends a bad read-mode byte. A design that advanced its index while idle, kept streaming stale data, or passed the bad mode on to the media port would be caught.

// File: rtl/ata_pkt_pkg.sv
package ata_pkt_pkg;

    localparam int PKT_BYTES  = 12;
    localparam int IDENT_SIZE = 32;
    localparam int SENSE_SIZE = 10;
    localparam int DINFO_SIZE = 6;

    localparam logic [7:0] ST_RESET = 8'h00;
    localparam logic [7:0] ST_OK    = 8'h50;
    localparam logic [7:0] ST_ERR   = 8'h51;
    localparam logic [7:0] ST_DRQ   = 8'h58;

    localparam logic [15:0] CODE_NODISC   = 16'h3A02;
    localparam logic [15:0] CODE_BADFIELD = 16'h2405;
    localparam logic [15:0] CODE_BADCMD   = 16'h2005;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_IDENT = 2'd1,
        SRC_SENSE = 2'd2,
        SRC_DINFO = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        MM_MODE1 = 2'd0,
        MM_GD    = 2'd1,
        MM_RAW   = 2'd2
    } mmode_e;

    typedef struct packed {
        logic          fail;
        logic [15:0]   code;
        src_e          src;
        logic [7:0]    base;
        logic [7:0]    len;
        logic          go_media;
        mmode_e        mode;
        logic [23:0]   lba;
        logic [23:0]   cnt;
    } dec_t;

    function automatic logic [7:0] ident_byte(input logic [7:0] k);
        logic [7:0] prod;
        prod = k * 8'd7;
        return 8'hA0 ^ prod;
    endfunction

    function automatic logic [7:0] clip8(input logic [7:0] req, input logic [7:0] lim);
        return (req > lim) ? lim : req;
    endfunction

endpackage

// File: rtl/pkt_decode.sv
module pkt_decode
    import ata_pkt_pkg::*;
#(
    parameter logic [7:0] OP_TEST  = 8'h00,
    parameter logic [7:0] OP_IDENT = 8'h11,
    parameter logic [7:0] OP_SENSE = 8'h13,
    parameter logic [7:0] OP_DINFO = 8'h14,
    parameter logic [7:0] OP_READ  = 8'h30
) (
    input  logic [8*PKT_BYTES-1:0] pkt,
    input  logic                   media_ready,
    output dec_t                   dec
);

    logic [7:0] b [PKT_BYTES];
    logic       mode_ok;
    logic       unused_bytes;

    for (genvar k = 0; k < PKT_BYTES; k++) begin : g_split
        assign b[k] = pkt[8*k +: 8];
    end

    assign unused_bytes = ^{b[5], b[6], b[7], b[11]};

    always_comb begin
        dec     = '0;
        mode_ok = 1'b1;
        case (b[0])
            OP_TEST: begin
                if (!media_ready) begin
                    dec.fail = 1'b1;
                    dec.code = CODE_NODISC;
                end
            end
            OP_IDENT: begin
                if (b[2] >= 8'(IDENT_SIZE)) begin
                    dec.fail = 1'b1;
                    dec.code = CODE_BADFIELD;
                end else begin
                    dec.src  = SRC_IDENT;
                    dec.base = b[2];
                    dec.len  = clip8(b[4], 8'(IDENT_SIZE) - b[2]);
                end
            end
            OP_SENSE: begin
                dec.src = SRC_SENSE;
                dec.len = clip8(b[4], 8'(SENSE_SIZE));
            end
            OP_DINFO: begin
                if (!media_ready) begin
                    dec.fail = 1'b1;
                    dec.code = CODE_NODISC;
                end else begin
                    dec.src = SRC_DINFO;
                    dec.len = clip8(b[4], 8'(DINFO_SIZE));
                end
            end
            OP_READ: begin
                dec.lba = {b[2], b[3], b[4]};
                dec.cnt = {b[8], b[9], b[10]};
                case (b[1])
                    8'h20, 8'h28: dec.mode = MM_MODE1;
                    8'h24:        dec.mode = MM_GD;
                    8'h30:        dec.mode = MM_RAW;
                    default:      mode_ok  = 1'b0;
                endcase
                if (!mode_ok) begin
                    dec.fail = 1'b1;
                    dec.code = CODE_BADFIELD;
                end else if (!media_ready) begin
                    dec.fail = 1'b1;
                    dec.code = CODE_NODISC;
                end else begin
                    dec.go_media = 1'b1;
                end
            end
            default: begin
                dec.fail = 1'b1;
                dec.code = CODE_BADCMD;
            end
        endcase
    end

endmodule

// File: rtl/resp_gen.sv
module resp_gen
    import ata_pkt_pkg::*;
(
    input  src_e                  src,
    input  logic [7:0]            idx,
    input  logic [15:0]           snap_code,
    input  logic [8*DINFO_SIZE-1:0] dinfo,
    output logic [7:0]            data
);

    always_comb begin
        case (src)
            SRC_IDENT: data = ident_byte(idx);
            SRC_SENSE: begin
                case (idx)
                    8'd0:    data = 8'hF0;
                    8'd2:    data = snap_code[7:0];
                    8'd8:    data = snap_code[15:8];
                    default: data = 8'h00;
                endcase
            end
            SRC_DINFO: data = 8'(dinfo >> {idx, 3'b000});
            default:   data = 8'hFF;
        endcase
    end

endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] base,
    input  logic [LEN_W-1:0] len,
    input  logic             rd_en,
    output logic             active,
    output logic [LEN_W-1:0] idx,
    output logic             done
);

    logic [LEN_W-1:0] left;

    assign done = active && rd_en && (left == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            left   <= '0;
        end else if (start) begin
            idx    <= base;
            left   <= len;
            active <= (len != '0);
        end else if (active && rd_en) begin
            idx  <= idx + LEN_W'(1);
            left <= left - LEN_W'(1);
            if (left == LEN_W'(1)) active <= 1'b0;
        end
    end

    assert_left_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
        active |-> (left != '0));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!active && !start) |=> $stable(idx));

endmodule

// File: rtl/ata_pkt_decoder.sv
module ata_pkt_decoder
    import ata_pkt_pkg::*;
#(
    parameter logic [7:0] OP_TEST  = 8'h00,
    parameter logic [7:0] OP_IDENT = 8'h11,
    parameter logic [7:0] OP_SENSE = 8'h13,
    parameter logic [7:0] OP_DINFO = 8'h14,
    parameter logic [7:0] OP_READ  = 8'h30
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pkt_valid,
    input  logic [95:0] pkt_bytes,
    input  logic [15:0] byte_limit,
    input  logic        media_ready,
    input  logic [47:0] dinfo_bytes,
    input  logic        rd_en,
    output logic [7:0]  rd_data,
    output logic        xfer_active,
    output logic        irq_pulse,
    output logic [7:0]  ata_status,
    output logic [7:0]  ata_error,
    output logic [15:0] xfer_blksize,
    output logic        media_req,
    output logic [23:0] media_lba,
    output logic [23:0] media_count,
    output logic [1:0]  media_mode
);

    localparam int LEN_W = 8;

    dec_t             dec;
    src_e             src_q;
    logic [15:0]      sense_code;
    logic [15:0]      snap_code;
    logic [LEN_W-1:0] idx;
    logic             done;
    logic [7:0]       gen_data;
    logic [LEN_W-1:0] start_len;

    pkt_decode #(
        .OP_TEST (OP_TEST),
        .OP_IDENT(OP_IDENT),
        .OP_SENSE(OP_SENSE),
        .OP_DINFO(OP_DINFO),
        .OP_READ (OP_READ)
    ) u_dec (
        .pkt        (pkt_bytes),
        .media_ready(media_ready),
        .dec        (dec)
    );

    assign start_len = dec.fail ? '0 : dec.len;

    xfer_ctrl #(.LEN_W(LEN_W)) u_xfer (
        .clk   (clk),
        .rst   (rst),
        .start (pkt_valid),
        .base  (dec.base),
        .len   (start_len),
        .rd_en (rd_en),
        .active(xfer_active),
        .idx   (idx),
        .done  (done)
    );

    resp_gen u_resp (
        .src      (src_q),
        .idx      (idx),
        .snap_code(snap_code),
        .dinfo    (dinfo_bytes),
        .data     (gen_data)
    );

    assign rd_data = xfer_active ? gen_data : 8'hFF;

    always_ff @(posedge clk) begin
        if (rst) begin
            ata_status   <= ST_RESET;
            ata_error    <= 8'h01;
            sense_code   <= '0;
            snap_code    <= '0;
            src_q        <= SRC_NONE;
            irq_pulse    <= 1'b0;
            media_req    <= 1'b0;
            media_lba    <= '0;
            media_count  <= '0;
            media_mode   <= MM_MODE1;
            xfer_blksize <= '0;
        end else begin
            irq_pulse <= 1'b0;
            media_req <= 1'b0;
            if (pkt_valid) begin
                irq_pulse    <= 1'b1;
                xfer_blksize <= byte_limit;
                snap_code    <= sense_code;
                src_q        <= dec.src;
                if (dec.fail) begin
                    sense_code <= dec.code;
                    ata_error  <= {dec.code[3:0], 4'h0};
                    ata_status <= ST_ERR;
                end else begin
                    sense_code <= '0;
                    ata_error  <= 8'h00;
                    ata_status <= (dec.len != '0) ? ST_DRQ : ST_OK;
                    if (dec.go_media) begin
                        media_req   <= 1'b1;
                        media_lba   <= dec.lba;
                        media_count <= dec.cnt;
                        media_mode  <= dec.mode;
                    end
                end
            end else if (done) begin
                ata_status <= ST_OK;
                irq_pulse  <= 1'b1;
            end
        end
    end

    assert_irq_on_accept_R2: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |=> irq_pulse);

    assert_err_nibble_R4: assert property (@(posedge clk) disable iff (rst)
        (ata_status == ST_ERR) |-> (ata_error[7:4] != 4'h0 && ata_error[3:0] == 4'h0));

    assert_media_ok_R8: assert property (@(posedge clk) disable iff (rst)
        media_req |-> (ata_status == ST_OK && media_mode != 2'd3));

    assert_drq_tracks_R9: assert property (@(posedge clk) disable iff (rst)
        xfer_active |-> (ata_status == ST_DRQ));

    assert_blk_capture_R10: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |=> (xfer_blksize == $past(byte_limit)));

endmodule

// File: tb/ata_pkt_decoder_tb_top.sv
`timescale 1ns/1ps
module ata_pkt_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        pkt_valid;
    logic [95:0] pkt_bytes;
    logic [15:0] byte_limit;
    logic        media_ready;
    logic [47:0] dinfo_bytes;
    logic        rd_en;
    logic [7:0]  rd_data;
    logic        xfer_active;
    logic        irq_pulse;
    logic [7:0]  ata_status;
    logic [7:0]  ata_error;
    logic [15:0] xfer_blksize;
    logic        media_req;
    logic [23:0] media_lba;
    logic [23:0] media_count;
    logic [1:0]  media_mode;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q [$];
    string cur_tag = "R9";
    logic [7:0] cb [12];

    always #10 clk = ~clk;

    ata_pkt_decoder dut_i (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_bytes(pkt_bytes),
        .byte_limit(byte_limit), .media_ready(media_ready), .dinfo_bytes(dinfo_bytes),
        .rd_en(rd_en), .rd_data(rd_data), .xfer_active(xfer_active), .irq_pulse(irq_pulse),
        .ata_status(ata_status), .ata_error(ata_error), .xfer_blksize(xfer_blksize),
        .media_req(media_req), .media_lba(media_lba), .media_count(media_count),
        .media_mode(media_mode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ident_exp(input int k);
        return 8'hA0 ^ 8'((k * 7) % 256);
    endfunction

    // monitor: compares each consumed byte against the scoreboard queue
    always @(negedge clk) begin
        if (rd_en && xfer_active) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_errors++;
                $display("FAIL %s: actual=%0h expected=<no byte>", cur_tag, rd_data);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (rd_data !== e) begin
                    n_errors++;
                    $display("FAIL %s: actual=%0h expected=%0h", cur_tag, rd_data, e);
                end
            end
        end
    end

    task automatic clear_cb();
        for (int k = 0; k < 12; k++) cb[k] = 8'h00;
    endtask

    task automatic send();
        @(posedge clk); #2;
        for (int k = 0; k < 12; k++) pkt_bytes[8*k +: 8] = cb[k];
        pkt_valid = 1'b1;
        @(posedge clk); #2;
        pkt_valid = 1'b0;
    endtask

    task automatic read_all(input string tag);
        cur_tag = tag;
        rd_en = 1'b1;
        while (1) begin
            @(posedge clk); #2;
            if (!xfer_active) break;
        end
        rd_en = 1'b0;
        chk({tag, " irq after last byte"}, irq_pulse, 1);
        chk({tag, " status after drain"}, ata_status, 8'h50);
        chk({tag, " scoreboard empty"}, exp_q.size(), 0);
    endtask

    task automatic read_n(input string tag, input int n);
        cur_tag = tag;
        rd_en = 1'b1;
        repeat (n) begin
            @(posedge clk); #2;
        end
        rd_en = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        rst = 1'b1; pkt_valid = 1'b0; pkt_bytes = '0; byte_limit = 16'h0200;
        media_ready = 1'b0; dinfo_bytes = 48'h665544332211; rd_en = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", ata_status, 8'h00);
        chk("R1 error", ata_error, 8'h01);
        chk("R1 active", xfer_active, 0);
        chk("R1 irq", irq_pulse, 0);
        chk("R1 media_req", media_req, 0);
        chk("R1 rd_data", rd_data, 8'hFF);

        // R3 test-ready without media -> no-disc
        clear_cb(); send();
        chk("R2 irq on accept", irq_pulse, 1);
        chk("R3 status no media", ata_status, 8'h51);
        chk("R4 error no-disc", ata_error, 8'h20);

        // R6 sense after failure
        clear_cb(); cb[0] = 8'h13; cb[4] = 8'd10;
        exp_q = '{8'hF0, 8'h00, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h3A, 8'h00};
        send();
        chk("R9 drq status", ata_status, 8'h58);
        chk("R9 active", xfer_active, 1);
        read_all("R6");

        // R6 sense again: code cleared, length clipped to 10
        clear_cb(); cb[0] = 8'h13; cb[4] = 8'd20;
        exp_q = '{8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        send(); read_all("R6 clip");

        // R3 test-ready with media
        media_ready = 1'b1;
        clear_cb(); send();
        chk("R3 status ready", ata_status, 8'h50);
        chk("R3 error ready", ata_error, 8'h00);

        // R4 unknown opcode
        clear_cb(); cb[0] = 8'h55; send();
        chk("R4 status badcmd", ata_status, 8'h51);
        chk("R4 error badcmd", ata_error, 8'h50);
        clear_cb(); cb[0] = 8'h13; cb[4] = 8'd3;
        exp_q = '{8'hF0, 8'h00, 8'h05};
        send(); read_all("R4 sense badcmd");

        // R5 identify and R10 block size
        byte_limit = 16'h1234;
        clear_cb(); cb[0] = 8'h11; cb[2] = 8'd4; cb[4] = 8'd5;
        for (int k = 4; k < 9; k++) exp_q.push_back(ident_exp(k));
        send();
        chk("R10 blksize", xfer_blksize, 16'h1234);
        read_all("R5");

        clear_cb(); cb[0] = 8'h11; cb[2] = 8'd30; cb[4] = 8'd10;
        exp_q.push_back(ident_exp(30)); exp_q.push_back(ident_exp(31));
        send(); read_all("R5 clip");

        clear_cb(); cb[0] = 8'h11; cb[2] = 8'd32; cb[4] = 8'd1; send();
        chk("R5 offset 32 status", ata_status, 8'h51);
        chk("R5 offset 32 error", ata_error, 8'h50);
        chk("R5 offset 32 active", xfer_active, 0);

        clear_cb(); cb[0] = 8'h11; cb[4] = 8'd0; send();
        chk("R9 zero length status", ata_status, 8'h50);
        chk("R9 zero length active", xfer_active, 0);

        // R7 disc info
        clear_cb(); cb[0] = 8'h14; cb[4] = 8'd9;
        exp_q = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
        send(); read_all("R7");
        media_ready = 1'b0;
        clear_cb(); cb[0] = 8'h14; cb[4] = 8'd4; send();
        chk("R7 no media error", ata_error, 8'h20);
        chk("R7 no media active", xfer_active, 0);

        // R8 media reads
        clear_cb(); cb[0] = 8'h30; cb[1] = 8'h20; send();
        chk("R8 no media error", ata_error, 8'h20);
        chk("R8 no media req", media_req, 0);
        media_ready = 1'b1;
        clear_cb(); cb[0] = 8'h30; cb[1] = 8'h24;
        cb[2] = 8'h12; cb[3] = 8'h34; cb[4] = 8'h56;
        cb[8] = 8'h00; cb[9] = 8'h01; cb[10] = 8'h02;
        send();
        chk("R8 req", media_req, 1);
        chk("R8 lba", media_lba, 24'h123456);
        chk("R8 count", media_count, 24'h000102);
        chk("R8 mode gd", media_mode, 2'd1);
        chk("R8 status", ata_status, 8'h50);
        @(posedge clk); #2;
        chk("R8 req one cycle", media_req, 0);
        clear_cb(); cb[0] = 8'h30; cb[1] = 8'h30; send();
        chk("R8 mode raw", media_mode, 2'd2);
        clear_cb(); cb[0] = 8'h30; cb[1] = 8'h28; send();
        chk("R8 mode 28", media_mode, 2'd0);
        clear_cb(); cb[0] = 8'h30; cb[1] = 8'h22; send();
        chk("R8 bad mode req", media_req, 0);
        chk("R8 bad mode error", ata_error, 8'h50);

        // R9 rd_en while idle is ignored
        rd_en = 1'b1;
        repeat (3) begin
            @(posedge clk); #2;
        end
        chk("R9 idle rd_data", rd_data, 8'hFF);
        chk("R9 idle active", xfer_active, 0);
        chk("R9 idle irq", irq_pulse, 0);
        rd_en = 1'b0;
        clear_cb(); cb[0] = 8'h11; cb[4] = 8'd3;
        for (int k = 0; k < 3; k++) exp_q.push_back(ident_exp(k));
        send(); read_all("R9 after idle");

        // R9 abort by new packet
        clear_cb(); cb[0] = 8'h11; cb[4] = 8'd8;
        for (int k = 0; k < 8; k++) exp_q.push_back(ident_exp(k));
        send(); read_n("R9 partial", 2);
        exp_q.delete();
        clear_cb(); send();
        chk("R9 abort active", xfer_active, 0);
        chk("R9 abort status", ata_status, 8'h50);
        chk("R9 abort rd_data", rd_data, 8'hFF);

        repeat (2) @(posedge clk);
        summary();
    end

endmodule